// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block collects six interrupt request sources for a small 8-bit microcontroller and presents the single most urgent one to the CPU. Two sources arrive as one-cycle pulses from neighbouring units: a display unit signals that a character block has finished, and a down-counting timer signals an underflow. A third source is an internal prescaler that ticks once every `TICK_DIV` clocks. The other three are asynchronous pins: two general external request pins and a vertical-sync input. Each pin passes through a synchronizer and an edge detector whose direction is set by a polarity bit.

Every source owns a request latch and an enable bit. A global disable flag blocks all requests to the CPU. The CPU sees a request-valid line and a 3-bit source index, which a combinational priority encoder recomputes every cycle. The CPU retires a request by acknowledging its index. Software can also drop latches through a write-only register port of four registers at addresses 0 to 3.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, all request latches, enable bits and polarity bits are 0. The tick gate (control bit 1) is 0. The global disable flag (control bit 0) is 1, so `irq_req_o` is 0.
- R2: Source indices are fixed: 0 display done, 1 external pin A, 2 external pin B, 3 timer underflow, 4 prescaler tick, 5 vertical sync. Pins A and B set their latches on an edge selected by polarity register (address 2) bits 0 and 1. A value of 0 means low-to-high and 1 means high-to-low. The opposite edge is ignored. A pin change made between two clock edges shows at the outputs after the third following rising edge.
- R3: The vertical-sync latch follows polarity bit 2 in the same way: 0 means rising and 1 means falling, with the same three-edge latency.
- R4: Any write to the polarity register blanks edge recognition on all three pins for the cycle after the write edge. A synchronized transition that lands in that cycle raises no request.
- R5: A one-cycle pulse on `disp_done_i` or `tmr_uflow_i` sets its latch at the next rising edge.
- R6: The prescaler sets latch 4 at rising edge number k·`TICK_DIV` after reset release, for k = 1, 2, …
- R7: While control bit 1 is 1, prescaler ticks are discarded. Clearing the bit lets later ticks through.
- R8: `irq_idx_o` is the lowest index whose latch and enable bit are both 1. Index 0 is the most urgent.
- R9: A latch whose enable bit (enable register, address 1, bit = index) is 0 stays pending but raises no request. It appears as soon as its enable bit is set.
- R10: While control register (address 3) bit 0 is 1, `irq_req_o` is 0. Latches still collect requests and appear once the bit is cleared.
- R11: `ack_valid_i` with `ack_idx_i` clears only that latch at the next rising edge. The next most urgent pending source then shows.
- R12: A write to address 0 clears each latch whose data bit is 0. A 1 bit leaves its latch unchanged.
- R13: Several events on a source while its latch is set merge into one pending request that a single acknowledge removes. A set and a clear in the same cycle leave the latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address (0 latches, 1 enables, 2 polarity, 3 control) |
| wr_data_i | input | DATA_W | Register write data |
| disp_done_i | input | 1 | One-cycle pulse: character block finished |
| tmr_uflow_i | input | 1 | One-cycle pulse: timer underflow |
| pin_exta_i | input | 1 | Asynchronous external request pin A |
| pin_extb_i | input | 1 | Asynchronous external request pin B |
| pin_vsync_i | input | 1 | Asynchronous vertical-sync input |
| ack_valid_i | input | 1 | CPU acknowledge strobe |
| ack_idx_i | input | 3 | Index of the acknowledged source |
| irq_req_o | output | 1 | Request to the CPU |
| irq_idx_o | output | 3 | Index of the most urgent enabled pending source |

## Verification
The outputs are a combinational function of registered state, so results are due on different edges. A write, acknowledge or source pulse shows after the single rising edge that captures it. A pin change shows after three rising edges: two synchronizer stages and the latch. A prescaler request shows after rising edge k·`TICK_DIV`, counted from reset release. The driver queues each expected value only once it has waited the exact number of rising edges for that path. Where timing matters, it also queues a "not yet" value one edge earlier. The monitor compares at the following falling edge, when no register is changing.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int N_SRC = 6;
  localparam int IDX_W = 3;
  localparam int N_PIN = 3;

  // source indices, index 0 most urgent
  localparam int SRC_DISP  = 0;
  localparam int SRC_EXTA  = 1;
  localparam int SRC_EXTB  = 2;
  localparam int SRC_TMR   = 3;
  localparam int SRC_TICK  = 4;
  localparam int SRC_VSYNC = 5;

  // register addresses
  localparam int REG_PEND = 0;
  localparam int REG_EN   = 1;
  localparam int REG_POL  = 2;
  localparam int REG_CTL  = 3;

  // control register bits
  localparam int CTL_GDIS  = 0;
  localparam int CTL_TGATE = 1;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic pol_i,
  input  logic resync_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;
  logic              hold_q, hold_d;
  logic              cur;

  assign cur = sync_q[STAGES-1];

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
    prev_d = cur;
    hold_d = resync_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      hold_q <= hold_d;
    end
  end

  // pol 0: low-to-high, pol 1: high-to-low; blanked right after a polarity write
  always_comb begin
    if (hold_q)     edge_o = 1'b0;
    else if (pol_i) edge_o = prev_q & ~cur;
    else            edge_o = ~prev_q & cur;
  end

  AST_EDGE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o); // R2
endmodule

// File: rtl/irq_tick_div.sv
module irq_tick_div #(
  parameter int DIV = 4096
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == LAST);

  always_comb begin
    if (tick_o) cnt_d = '0;
    else        cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R6
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 6,
  parameter int W = 3
) (
  input  logic [N-1:0] req_i,
  output logic         valid_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    valid_o = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int TICK_DIV    = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              disp_done_i,
  input  logic              tmr_uflow_i,
  input  logic              pin_exta_i,
  input  logic              pin_extb_i,
  input  logic              pin_vsync_i,
  input  logic              ack_valid_i,
  input  logic [IDX_W-1:0]  ack_idx_i,
  output logic              irq_req_o,
  output logic [IDX_W-1:0]  irq_idx_o
);
  localparam logic [N_SRC-1:0] ONE = N_SRC'(1);

  logic [N_SRC-1:0] pend_q, pend_d;
  logic [N_SRC-1:0] en_q;
  logic [N_PIN-1:0] pol_q;
  logic             gdis_q, tgate_q;

  logic             we_pend, we_en, we_pol, we_ctl;
  logic [N_PIN-1:0] pins, edges;
  logic             tick;
  logic [N_SRC-1:0] set_vec, clr_vec, active;
  logic             any_act;

  // write decode
  always_comb begin
    we_pend = wr_en_i && (wr_addr_i == ADDR_W'(REG_PEND));
    we_en   = wr_en_i && (wr_addr_i == ADDR_W'(REG_EN));
    we_pol  = wr_en_i && (wr_addr_i == ADDR_W'(REG_POL));
    we_ctl  = wr_en_i && (wr_addr_i == ADDR_W'(REG_CTL));
  end

  // pin edge detectors: bit 0 pin A, bit 1 pin B, bit 2 vertical sync
  assign pins = {pin_vsync_i, pin_extb_i, pin_exta_i};

  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    irq_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_i    (pins[g]),
      .pol_i    (pol_q[g]),
      .resync_i (we_pol),
      .edge_o   (edges[g])
    );
  end

  irq_tick_div #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  // request latch next state: set wins over clear
  always_comb begin
    set_vec            = '0;
    set_vec[SRC_DISP]  = disp_done_i;
    set_vec[SRC_EXTA]  = edges[0];
    set_vec[SRC_EXTB]  = edges[1];
    set_vec[SRC_TMR]   = tmr_uflow_i;
    set_vec[SRC_TICK]  = tick & ~tgate_q;
    set_vec[SRC_VSYNC] = edges[2];

    clr_vec = '0;
    if (ack_valid_i) clr_vec = clr_vec | (ONE << ack_idx_i);
    if (we_pend)     clr_vec = clr_vec | ~wr_data_i[N_SRC-1:0];

    pend_d = (pend_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      pol_q   <= '0;
      gdis_q  <= 1'b1;
      tgate_q <= 1'b0;
    end else begin
      if (we_en)  en_q  <= wr_data_i[N_SRC-1:0];
      if (we_pol) pol_q <= wr_data_i[N_PIN-1:0];
      if (we_ctl) begin
        gdis_q  <= wr_data_i[CTL_GDIS];
        tgate_q <= wr_data_i[CTL_TGATE];
      end
    end
  end

  // selection
  assign active = pend_q & en_q;

  irq_prio_enc #(.N(N_SRC), .W(IDX_W)) u_enc (
    .req_i   (active),
    .valid_o (any_act),
    .idx_o   (irq_idx_o)
  );

  assign irq_req_o = any_act & ~gdis_q;

  AST_IDX_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (pend_q[irq_idx_o] && en_q[irq_idx_o])); // R9
  AST_NO_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> ((pend_q & en_q & ((ONE << irq_idx_o) - ONE)) == '0)); // R8
  AST_GDIS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (we_ctl && wr_data_i[CTL_GDIS]) |=> !irq_req_o); // R10
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_i && (ack_idx_i < IDX_W'(N_SRC)) && !set_vec[ack_idx_i])
      |=> !pend_q[$past(ack_idx_i)]); // R11
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !ack_valid_i) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R13
endmodule

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data;
  logic       disp, tmr, pa, pb, pv;
  logic       ack_v;
  logic [2:0] ack_i;
  logic       irq_req;
  logic [2:0] irq_idx;

  int checks_n = 0;
  int fail_n   = 0;
  int cyc      = 0;
  bit done     = 0;

  typedef struct {
    bit         req;
    logic [2:0] idx;
    string      tag;
  } exp_t;
  exp_t exp_q[$];
  event chk_ev;

  always #2.5 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .disp_done_i(disp), .tmr_uflow_i(tmr),
    .pin_exta_i(pa), .pin_extb_i(pb), .pin_vsync_i(pv),
    .ack_valid_i(ack_v), .ack_idx_i(ack_i),
    .irq_req_o(irq_req), .irq_idx_o(irq_idx)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // monitor: pops expectations and compares at the falling edge
  task automatic drain();
    while (exp_q.size() > 0) begin
      exp_t e = exp_q.pop_front();
      checks_n++;
      if (irq_req !== e.req || (e.req && irq_idx !== e.idx)) begin
        fail_n++;
        $display("FAIL %s: actual req=%0b idx=%0d expected req=%0b idx=%0d",
                 e.tag, irq_req, irq_idx, e.req, e.idx);
      end
    end
  endtask

  initial forever begin
    @(chk_ev);
    drain();
  end

  task automatic expect_out(bit req, logic [2:0] idx, string tag);
    exp_t e;
    e.req = req; e.idx = idx; e.tag = tag;
    exp_q.push_back(e);
    -> chk_ev;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ack(logic [2:0] i);
    @(negedge clk); ack_v = 1'b1; ack_i = i;
    @(negedge clk); ack_v = 1'b0;
  endtask

  task automatic pulse_disp();
    @(negedge clk); disp = 1'b1;
    @(negedge clk); disp = 1'b0;
  endtask

  task automatic pulse_tmr();
    @(negedge clk); tmr = 1'b1;
    @(negedge clk); tmr = 1'b0;
  endtask

  task automatic wait_neg(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cyc(int c);
    while (cyc != c) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fail_n++;
      checks_n++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks_n, fail_n);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    disp = 1'b0; tmr = 1'b0; pa = 1'b0; pb = 1'b0; pv = 1'b0;
    ack_v = 1'b0; ack_i = '0;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(1);
    expect_out(0, 0, "R1 reset output");

    // R1 / R10: global disable set after reset
    wr(8'd1, 8'h3F);
    pulse_disp();
    expect_out(0, 0, "R1 disable flag set at reset");
    wr(8'd3, 8'h00);
    expect_out(1, 0, "R10 cleared flag releases request");
    ack(3'd0);
    expect_out(0, 0, "R11 ack clears display");

    // R5 / R8 / R11
    pulse_tmr();
    expect_out(1, 3, "R5 timer pulse");
    pulse_disp();
    expect_out(1, 0, "R8 display over timer");
    ack(3'd0);
    expect_out(1, 3, "R11 next highest shown");
    ack(3'd3);
    expect_out(0, 0, "R11 last ack");

    // R2 pin A rising with exact latency
    @(negedge clk); pa = 1'b1;
    wait_neg(2);
    expect_out(0, 0, "R2 not yet after two edges");
    wait_neg(1);
    expect_out(1, 1, "R2 pin A rising");
    ack(3'd1);
    @(negedge clk); pa = 1'b0;
    wait_neg(4);
    expect_out(0, 0, "R2 falling ignored in rising mode");

    // R2 pin A falling mode
    wr(8'd2, 8'h01);
    @(negedge clk); pa = 1'b1;
    wait_neg(4);
    expect_out(0, 0, "R2 rising ignored in falling mode");
    @(negedge clk); pa = 1'b0;
    wait_neg(3);
    expect_out(1, 1, "R2 pin A falling");
    ack(3'd1);

    // R2 pin B rising
    @(negedge clk); pb = 1'b1;
    wait_neg(3);
    expect_out(1, 2, "R2 pin B rising");
    ack(3'd2);

    // R3 vertical sync
    @(negedge clk); pv = 1'b1;
    wait_neg(3);
    expect_out(1, 5, "R3 vsync rising");
    ack(3'd5);
    wr(8'd2, 8'h05);
    @(negedge clk); pv = 1'b0;
    wait_neg(3);
    expect_out(1, 5, "R3 vsync falling");
    ack(3'd5);
    @(negedge clk); pv = 1'b1;
    wait_neg(4);
    expect_out(0, 0, "R3 rising ignored in falling mode");

    // R4 polarity write blanks the cycle after it
    @(negedge clk); pb = 1'b0;
    wait_neg(4);
    expect_out(0, 0, "R4 setup pin B low");
    @(negedge clk); pb = 1'b1;
    wr(8'd2, 8'h05);
    wait_neg(2);
    expect_out(0, 0, "R4 edge blanked by polarity write");

    // R9 enable mask
    wr(8'd1, 8'h37);
    pulse_tmr();
    expect_out(0, 0, "R9 disabled source silent");
    wr(8'd1, 8'h3F);
    expect_out(1, 3, "R9 pending shown once enabled");

    // R12 software clear
    wr(8'd0, 8'h3F);
    expect_out(1, 3, "R12 ones leave latch");
    wr(8'd0, 8'h37);
    expect_out(0, 0, "R12 zero bit clears latch");

    // R13 merge and set-wins
    pulse_tmr();
    pulse_tmr();
    expect_out(1, 3, "R13 two pulses pending");
    ack(3'd3);
    expect_out(0, 0, "R13 single ack clears merged");
    @(negedge clk); ack_v = 1'b1; ack_i = 3'd3; tmr = 1'b1;
    @(negedge clk); ack_v = 1'b0; tmr = 1'b0;
    expect_out(1, 3, "R13 set wins over same-cycle clear");
    ack(3'd3);

    // R10 again
    pulse_disp();
    wr(8'd3, 8'h01);
    expect_out(0, 0, "R10 flag blocks request");
    wr(8'd3, 8'h00);
    expect_out(1, 0, "R10 latched request reappears");
    ack(3'd0);

    // R6 prescaler period
    wait_cyc(4095);
    expect_out(0, 0, "R6 no tick before period");
    wait_neg(1);
    expect_out(1, 4, "R6 first tick");
    ack(3'd4);
    wait_cyc(8191);
    expect_out(0, 0, "R6 no tick before second period");
    wait_neg(1);
    expect_out(1, 4, "R6 second tick");
    ack(3'd4);

    // R7 tick gate
    wr(8'd3, 8'h02);
    wait_cyc(12289);
    expect_out(0, 0, "R7 gated tick discarded");
    wr(8'd3, 8'h00);
    wait_cyc(16383);
    expect_out(0, 0, "R7 nothing before next period");
    wait_neg(1);
    expect_out(1, 4, "R7 tick resumes after ungating");

    wait_neg(1);
    drain();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks_n, fail_n);
    $finish;
  end
endmodule